// File: doc/BRIEF.md
# Receive Data Edge Conditioner

This block sits between a receiver's raw demodulated bit and the data pin that a microcontroller watches. The raw bit first passes through a short flop chain. It is then looked at only when an extended timing tick strobes, so every transition of the cleaned output lands on a tick boundary. Every interval between output edges is therefore a whole number of ticks.

On top of that alignment, a runtime spacing value sets the fewest ticks allowed between two output edges. A change in the input that appears too soon after the last output edge is not passed on. If the input still differs from the output once the spacing has elapsed, the output takes it on that tick. This drops short spikes and caps how often the microcontroller can be interrupted.

A gate from the mode sequencer marks receive mode. While the gate is low, the output rests high and the spacing count starts over, so the first edge of a new burst is a falling one. A one-cycle strobe marks each output transition that happens in receive mode.

Top module: `rx_data_cleaner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, data_o is 1 and edge_o is 0.
- R2: With gate_i high, data_o changes only in the cycle that follows a clock edge at which tick_i was 1.
- R3: The raw bit passes through SYNC_STAGES flops (default 2) before it is looked at. A value of raw_i that is present only in the last cycle before a tick has no effect on that tick.
- R4: With min_gap_i held constant, two consecutive output edges are at least max(min_gap_i, 1) ticks apart.
- R5: A sampled input that differs from data_o on a tick that comes less than min_gap_i ticks after the last output edge leaves data_o unchanged.
- R6: If the sampled input still differs from data_o on the first tick at which the spacing is met, data_o takes the sampled value on that tick.
- R7: With min_gap_i equal to 0, data_o takes the sampled value on every tick.
- R8: One cycle after gate_i is seen low, data_o is 1 and the spacing count is cleared. After the gate rises again, the first edge comes no earlier than the min_gap_i-th tick.
- R9: edge_o is 1 for exactly the one cycle in which data_o shows a tick-driven change. A change forced by the gate gives no strobe.
- R10: The spacing count saturates. After any quiet stretch of at least min_gap_i ticks, the first differing sample produces an edge at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle extended timing tick strobe |
| gate_i | input | 1 | Receive-mode gate from the mode sequencer |
| raw_i | input | 1 | Raw demodulated data bit |
| min_gap_i | input | GAP_W | Minimum spacing between output edges, in ticks |
| data_o | output | 1 | Cleaned data bit |
| edge_o | output | 1 | One-cycle strobe on each output transition |

## Verification
Four properties are checked on every cycle: the output changes only after a tick, it rests high while the gate is low, every strobe coincides with a real transition, and the spacing count stays within its limit. The bench scenarios cover what those properties cannot see. These are the spacing enforced between edges, the dropping of spikes and the late follow-up, the masking of a value that arrives one cycle before a tick, and the delayed first edge after the gate reopens.

// File: rtl/dso_pkg.sv
package dso_pkg;
  localparam logic IDLE_LEVEL = 1'b1;

  function automatic logic gap_met(input logic [15:0] cnt, input logic [15:0] gap);
    return (17'(cnt) + 17'd1) >= 17'(gap);
  endfunction
endpackage

// File: rtl/dso_sync.sv
module dso_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= RST_VAL;
        else         chain_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= RST_VAL;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dso_gap_cnt.sv
module dso_gap_cnt #(
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [GAP_W-1:0] min_gap_i,
  output logic             gap_ok_o
);
  import dso_pkg::*;

  logic [GAP_W-1:0] cnt_q;

  // ticks since last output edge, held once the minimum is reached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (step_i) begin
      if (restart_i)              cnt_q <= '0;
      else if (cnt_q < min_gap_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_ok_o = gap_met(16'(cnt_q), 16'(min_gap_i));

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(min_gap_i) && $past(cnt_q <= min_gap_i)) |-> (cnt_q <= min_gap_i)); // R10
endmodule

// File: rtl/dso_out_reg.sv
module dso_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic step_i,
  input  logic sample_i,
  input  logic gap_ok_i,
  output logic fire_o,
  output logic data_o,
  output logic edge_o
);
  import dso_pkg::*;

  logic data_q, edge_q;

  assign fire_o = step_i && (sample_i != data_q) && gap_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= IDLE_LEVEL;
      edge_q <= 1'b0;
    end else if (!gate_i) begin
      data_q <= IDLE_LEVEL;
      edge_q <= 1'b0;
    end else begin
      edge_q <= fire_o;
      if (fire_o) data_q <= sample_i;
    end
  end

  assign data_o = data_q;
  assign edge_o = edge_q;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gate_i) |-> data_o); // R8
  AST_EDGE_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (data_o != $past(data_o))); // R9
  AST_NO_EDGE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> !edge_o); // R9
endmodule

// File: rtl/rx_data_cleaner.sv
module rx_data_cleaner #(
  parameter int unsigned GAP_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             raw_i,
  input  logic [GAP_W-1:0] min_gap_i,
  output logic             data_o,
  output logic             edge_o
);
  import dso_pkg::*;

  logic raw_s, step, gap_ok, fire;

  assign step = tick_i && gate_i;

  dso_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(IDLE_LEVEL)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (raw_s)
  );

  dso_gap_cnt #(
    .GAP_W(GAP_W)
  ) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!gate_i),
    .step_i   (step),
    .restart_i(fire),
    .min_gap_i(min_gap_i),
    .gap_ok_o (gap_ok)
  );

  dso_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_i  (gate_i),
    .step_i  (step),
    .sample_i(raw_s),
    .gap_ok_i(gap_ok),
    .fire_o  (fire),
    .data_o  (data_o),
    .edge_o  (edge_o)
  );

  AST_ON_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gate_i) && (data_o != $past(data_o))) |-> $past(tick_i)); // R2
endmodule

// File: tb/tb_rx_data_cleaner.sv
module tb_rx_data_cleaner;
  localparam int GAP_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, gate_i = 1'b0, raw_i = 1'b1;
  logic [GAP_W-1:0] min_gap_i = '0;
  logic data_o, edge_o;

  int checks = 0, errors = 0;
  bit m_data = 1'b1, m_edge = 1'b0, seen_edge = 1'b0, done = 1'b0;
  int m_cnt = 0, dut_since = 0;

  always #5 clk_i = ~clk_i;

  rx_data_cleaner #(.GAP_W(GAP_W), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .gate_i(gate_i),
    .raw_i(raw_i), .min_gap_i(min_gap_i), .data_o(data_o), .edge_o(edge_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference for one tick, from the requirements
  task automatic model_step(bit r);
    int gap = int'(min_gap_i);
    if (r != m_data && m_cnt + 1 >= gap) begin
      m_data = r; m_edge = 1'b1; m_cnt = 0;
    end else begin
      m_edge = 1'b0;
      if (m_cnt < gap) m_cnt++;
    end
  endtask

  task automatic observe(string req);
    int gap = int'(min_gap_i);
    int need = (gap > 1) ? gap : 1;
    chk(req, data_o, m_data);
    chk({req, "/R9"}, edge_o, m_edge);
    if (edge_o) begin
      if (seen_edge) begin
        checks++;
        if (dut_since + 1 < need) begin
          errors++;
          $display("FAIL R4: actual interval %0d expected >= %0d", dut_since + 1, need);
        end
      end
      seen_edge = 1'b1; dut_since = 0;
    end else dut_since++;
  endtask

  // raw held from the start of the tick period; tick strobes on its 4th cycle
  task automatic do_tick(bit r, string req);
    @(negedge clk_i); raw_i = r; tick_i = 1'b0;
    @(negedge clk_i); chk("R9 strobe width", edge_o, 0);
    repeat (2) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    model_step(r);
    observe(req);
  endtask

  task automatic gate_cycle(int len);
    @(negedge clk_i); gate_i = 1'b0;
    @(negedge clk_i);
    chk("R8 forced high", data_o, 1);
    chk("R9 no gate strobe", edge_o, 0);
    repeat (len) @(negedge clk_i);
    gate_i = 1'b1;
    m_data = 1'b1; m_cnt = 0; seen_edge = 1'b0;
  endtask

  task automatic set_gap(int g);
    @(negedge clk_i); min_gap_i = GAP_W'(g); seen_edge = 1'b0;
  endtask

  initial begin
    bit cur;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 data in reset", data_o, 1);
    chk("R1 edge in reset", edge_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 data after reset", data_o, 1);
    chk("R1 edge after reset", edge_o, 0);
    gate_i = 1'b1;

    // R7: no spacing, follow every tick
    set_gap(0);
    do_tick(0, "R7"); do_tick(1, "R7"); do_tick(0, "R7");
    do_tick(0, "R7"); do_tick(1, "R7");

    // R3: value present only in the last cycle before a tick is not seen
    @(negedge clk_i); raw_i = 1'b1; tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    raw_i = 1'b0; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    model_step(1'b1);
    observe("R3");
    do_tick(0, "R3 follow");

    // R10, R5, R6 with spacing 3
    set_gap(3);
    do_tick(0, "R10 quiet"); do_tick(0, "R10 quiet"); do_tick(0, "R10 quiet");
    do_tick(1, "R10 immediate");
    do_tick(0, "R5 spike dropped");
    do_tick(1, "R5 hold");
    do_tick(0, "R6 late follow");
    do_tick(0, "R6 hold");

    // R8: gate drop with output low, then delayed first edge
    gate_cycle(3);
    set_gap(2);
    do_tick(0, "R8 first tick blocked");
    do_tick(0, "R8 second tick edge");

    // random segments
    cur = 1'b0;
    for (int seg = 0; seg < 12; seg++) begin
      set_gap(int'($urandom_range(0, 5)));
      if (seg % 4 == 3) gate_cycle(int'($urandom_range(1, 4)));
      for (int t = 0; t < 40; t++) begin
        if ($urandom_range(0, 99) < 35) cur = ~cur;
        do_tick(cur, "R4/R5/R6 random");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule